// File: doc/BRIEF.md
# Reorder Buffer with Flush

This block keeps speculatively executed instructions in program order so that their effects become architectural strictly in the order they were issued. Each issued instruction takes the next slot of a circular buffer. The slot index is returned as the rename tag, and dependent instructions refer to that tag instead of a register name. Execution units post results on a broadcast bus that is tagged with the slot index. A completed but not yet retired value can be read back through an operand lookup port, which searches by architectural register and reports the youngest in-flight producer.

The oldest slot retires once its result is present. Depending on its kind, it writes the register file, performs a store, or does nothing. A branch that is flagged as mispredicted discards every younger slot in the same cycle it retires. An instruction that is flagged with an exception raises an exception output instead of writing state, and it also discards the buffer. At most one slot retires per cycle. A new slot can be taken in the same cycle that the oldest one leaves, even when the buffer is full.

Top module: `rob_core`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, and retire_valid, rf_we, st_we, exc_valid, flush and lk_hit are all 0.
- R2: A slot is taken when alloc_valid, rs_free and alloc_ready are all 1. Tags are handed out as 0, 1, 2 and so on, modulo ENTRIES. alloc_ready is 0 while all ENTRIES slots are occupied and the oldest slot is not retiring in that cycle.
- R3: A broadcast with wb_valid=1 to an occupied tag stores wb_value, wb_addr, wb_exc and wb_mispred into that slot and marks it complete. A broadcast to an unoccupied tag has no effect.
- R4: retire_valid is 1 only when the oldest occupied slot is complete. At most one slot retires per cycle. retire_tag follows allocation order and equals that slot's tag.
- R5: A retiring slot of kind register (alloc_kind 0) that has no exception drives rf_we=1, with rf_addr set to its destination and rf_data set to its result.
- R6: A retiring slot of kind store (alloc_kind 1) that has no exception drives st_we=1, with st_addr set to its broadcast address and st_data set to its result. rf_we stays 0.
- R7: The lookup returns the youngest occupied slot of kind register whose destination equals lk_reg. It reports lk_hit, lk_tag, lk_ready (result present) and lk_value (the result when ready, 0 otherwise). All outputs are 0 when no slot matches.
- R8: A retiring slot of kind branch (alloc_kind 2) that was flagged as mispredicted asserts flush. All younger slots are discarded, the buffer is empty in the next cycle, and the next tag handed out is the branch's tag plus one. Kind 3 and correctly predicted branches retire with no effect.
- R9: A retiring slot that was flagged with an exception asserts exc_valid, sets exc_pc to its PC and asserts flush. It writes neither the register file nor the store port, whatever its kind.
- R10: In a flush cycle alloc_ready is 0, so no slot is taken.
- R11: When the buffer is full and the oldest slot retires, alloc_ready is 1, and the new slot reuses the freed tag in the same cycle.
- R12: With rs_free=0 no slot is taken, even if alloc_valid and alloc_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Issue request |
| rs_free | input | 1 | A reservation station is free for the request |
| alloc_kind | input | 2 | 0 register, 1 store, 2 branch, 3 no effect |
| alloc_pc | input | PC_W | PC of the issued instruction |
| alloc_dest | input | AREG_W | Destination architectural register |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Tag given to the issued instruction |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Tag of the broadcast result |
| wb_value | input | XLEN | Result value (store data for stores) |
| wb_addr | input | XLEN | Store address |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispred | input | 1 | Branch was mispredicted |
| lk_reg | input | AREG_W | Register looked up |
| lk_hit | output | 1 | An in-flight producer exists |
| lk_tag | output | TAG_W | Tag of the youngest producer |
| lk_ready | output | 1 | Producer result present |
| lk_value | output | XLEN | Producer result |
| retire_valid | output | 1 | Oldest slot retires this cycle |
| retire_tag | output | TAG_W | Tag of the retiring slot |
| rf_we | output | 1 | Register file write |
| rf_addr | output | AREG_W | Register file write address |
| rf_data | output | XLEN | Register file write data |
| st_we | output | 1 | Store request |
| st_addr | output | XLEN | Store address |
| st_data | output | XLEN | Store data |
| exc_valid | output | 1 | Exception at retirement |
| exc_pc | output | PC_W | PC of the excepting instruction |
| flush | output | 1 | All younger slots are discarded |

## Verification
The bench builds the block with ENTRIES=4 and AREG_W=3. With four slots, a full buffer, tag wrap-around and a retire-and-allocate in a full cycle all occur within a few cycles of each other. With eight registers, random traffic often has several in-flight producers of one register, which exercises the youngest-match rule. XLEN and PC_W stay at 32.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer.
// Assumes the kind encoding used at the allocation port of rob_core.
package rob_pkg;
    typedef enum logic [1:0] {
        K_REG    = 2'd0,
        K_STORE  = 2'd1,
        K_BRANCH = 2'd2,
        K_PLAIN  = 2'd3
    } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head and tail pointers of the circular buffer, each with one extra wrap bit.
// Assumes ENTRIES is a power of two and at least 2, and that flush only
// comes together with pop (a flush always happens at retirement).
module rob_ptrs #(
    parameter int ENTRIES = 8,
    localparam int TAG_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [TAG_W-1:0] head_idx,
    output logic [TAG_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);
    localparam logic [TAG_W:0] PTR_ONE  = (TAG_W+1)'(1);
    localparam logic [TAG_W:0] PTR_ZERO = '0;

    logic [TAG_W:0] head_q, tail_q, head_nx;

    // head moves by one on every retirement
    assign head_nx = pop ? head_q + PTR_ONE : head_q;

    // pointer registers; a flush collapses the tail onto the new head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= PTR_ZERO;
            tail_q <= PTR_ZERO;
        end else begin
            head_q <= head_nx;
            if (flush)
                tail_q <= head_nx;
            else if (push)
                tail_q <= tail_q + PTR_ONE;
        end
    end

    // full and empty differ only in the wrap bit
    assign head_idx = head_q[TAG_W-1:0];
    assign tail_idx = tail_q[TAG_W-1:0];
    assign empty    = (head_q == tail_q);
    assign full     = (head_q[TAG_W] != tail_q[TAG_W]) &&
                      (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]);
endmodule

// File: rtl/rob_store.sv
// Per-slot state of the buffer: occupancy, kind, PC, destination, result,
// store address and the completion, exception and mispredict flags.
// Assumes allocation never targets an occupied slot unless that slot is
// being freed in the same cycle; allocation wins over freeing.
module rob_store
    import rob_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int XLEN    = 32,
    parameter int PC_W    = 32,
    parameter int AREG_W  = 5,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_we,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  kind_e             alloc_kind,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic [AREG_W-1:0] alloc_dest,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [XLEN-1:0]   wb_value,
    input  logic [XLEN-1:0]   wb_addr,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    input  logic              free_we,
    input  logic [TAG_W-1:0]  free_idx,
    input  logic              clear_all,
    output logic              valid_o [ENTRIES],
    output logic              done_o  [ENTRIES],
    output logic              exc_o   [ENTRIES],
    output logic              mis_o   [ENTRIES],
    output kind_e             kind_o  [ENTRIES],
    output logic [PC_W-1:0]   pc_o    [ENTRIES],
    output logic [AREG_W-1:0] dest_o  [ENTRIES],
    output logic [XLEN-1:0]   value_o [ENTRIES],
    output logic [XLEN-1:0]   addr_o  [ENTRIES]
);
    // slot update: result capture, then freeing, then allocation
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n) begin
                valid_o[e] <= 1'b0;
                done_o[e]  <= 1'b0;
                exc_o[e]   <= 1'b0;
                mis_o[e]   <= 1'b0;
                kind_o[e]  <= K_PLAIN;
                pc_o[e]    <= '0;
                dest_o[e]  <= '0;
                value_o[e] <= '0;
                addr_o[e]  <= '0;
            end else begin
                if (wb_valid && wb_tag == TAG_W'(e) && valid_o[e]) begin
                    done_o[e]  <= 1'b1;
                    value_o[e] <= wb_value;
                    addr_o[e]  <= wb_addr;
                    exc_o[e]   <= wb_exc;
                    mis_o[e]   <= wb_mispred;
                end
                if (clear_all || (free_we && free_idx == TAG_W'(e)))
                    valid_o[e] <= 1'b0;
                if (alloc_we && alloc_idx == TAG_W'(e)) begin
                    valid_o[e] <= 1'b1;
                    done_o[e]  <= 1'b0;
                    exc_o[e]   <= 1'b0;
                    mis_o[e]   <= 1'b0;
                    kind_o[e]  <= alloc_kind;
                    pc_o[e]    <= alloc_pc;
                    dest_o[e]  <= alloc_dest;
                end
            end
        end
    end
endmodule

// File: rtl/rob_lookup.sv
// Operand lookup: finds the youngest occupied register-kind slot that
// writes the requested register. Assumes occupied slots are contiguous
// from the head, so the offset from the head orders them by age.
module rob_lookup
    import rob_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int XLEN    = 32,
    parameter int AREG_W  = 5,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input  logic [TAG_W-1:0]  head_idx,
    input  logic              valid_i [ENTRIES],
    input  logic              done_i  [ENTRIES],
    input  kind_e             kind_i  [ENTRIES],
    input  logic [AREG_W-1:0] dest_i  [ENTRIES],
    input  logic [XLEN-1:0]   value_i [ENTRIES],
    input  logic [AREG_W-1:0] lk_reg,
    output logic              lk_hit,
    output logic [TAG_W-1:0]  lk_tag,
    output logic              lk_ready,
    output logic [XLEN-1:0]   lk_value
);
    logic [TAG_W-1:0] slot [ENTRIES];
    logic [ENTRIES-1:0] match;

    // one comparator per age position
    for (genvar i = 0; i < ENTRIES; i++) begin : g_age
        assign slot[i]  = head_idx + TAG_W'(i);
        assign match[i] = valid_i[slot[i]] && (kind_i[slot[i]] == K_REG) &&
                          (dest_i[slot[i]] == lk_reg);
    end

    // the last match in age order is the youngest producer
    always_comb begin
        lk_hit   = 1'b0;
        lk_tag   = '0;
        lk_ready = 1'b0;
        lk_value = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_hit   = 1'b1;
                lk_tag   = slot[i];
                lk_ready = done_i[slot[i]];
                lk_value = done_i[slot[i]] ? value_i[slot[i]] : '0;
            end
        end
    end
endmodule

// File: rtl/rob_core.sv
// Reorder buffer top: allocates slots in program order, captures tagged
// results, serves operand lookups and retires the oldest slot once its
// result is present, flushing on a mispredicted branch or an exception.
// Assumes ENTRIES is a power of two and at least 2; outputs on the retire
// side come from registered state within the same cycle.
module rob_core
    import rob_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int XLEN    = 32,
    parameter int PC_W    = 32,
    parameter int AREG_W  = 5,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              rs_free,
    input  logic [1:0]        alloc_kind,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic [AREG_W-1:0] alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [XLEN-1:0]   wb_value,
    input  logic [XLEN-1:0]   wb_addr,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    input  logic [AREG_W-1:0] lk_reg,
    output logic              lk_hit,
    output logic [TAG_W-1:0]  lk_tag,
    output logic              lk_ready,
    output logic [XLEN-1:0]   lk_value,
    output logic              retire_valid,
    output logic [TAG_W-1:0]  retire_tag,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_addr,
    output logic [XLEN-1:0]   rf_data,
    output logic              st_we,
    output logic [XLEN-1:0]   st_addr,
    output logic [XLEN-1:0]   st_data,
    output logic              exc_valid,
    output logic [PC_W-1:0]   exc_pc,
    output logic              flush
);
    logic [TAG_W-1:0]  head_idx, tail_idx;
    logic              full, empty;
    logic              alloc_fire, retire, flush_now;
    logic              v_a [ENTRIES];
    logic              d_a [ENTRIES];
    logic              x_a [ENTRIES];
    logic              m_a [ENTRIES];
    kind_e             k_a [ENTRIES];
    logic [PC_W-1:0]   p_a [ENTRIES];
    logic [AREG_W-1:0] r_a [ENTRIES];
    logic [XLEN-1:0]   val_a [ENTRIES];
    logic [XLEN-1:0]   adr_a [ENTRIES];
    kind_e             h_kind;
    logic              h_exc;

    rob_ptrs #(.ENTRIES(ENTRIES)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .push(alloc_fire), .pop(retire),
        .flush(flush_now), .head_idx(head_idx), .tail_idx(tail_idx),
        .full(full), .empty(empty)
    );

    rob_store #(.ENTRIES(ENTRIES), .XLEN(XLEN), .PC_W(PC_W), .AREG_W(AREG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc_we(alloc_fire), .alloc_idx(tail_idx), .alloc_kind(kind_e'(alloc_kind)),
        .alloc_pc(alloc_pc), .alloc_dest(alloc_dest),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_addr(wb_addr),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred),
        .free_we(retire), .free_idx(head_idx), .clear_all(flush_now),
        .valid_o(v_a), .done_o(d_a), .exc_o(x_a), .mis_o(m_a), .kind_o(k_a),
        .pc_o(p_a), .dest_o(r_a), .value_o(val_a), .addr_o(adr_a)
    );

    rob_lookup #(.ENTRIES(ENTRIES), .XLEN(XLEN), .AREG_W(AREG_W)) u_lookup (
        .head_idx(head_idx), .valid_i(v_a), .done_i(d_a), .kind_i(k_a),
        .dest_i(r_a), .value_i(val_a), .lk_reg(lk_reg),
        .lk_hit(lk_hit), .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_value(lk_value)
    );

    // retirement decision for the oldest slot
    assign h_kind    = k_a[head_idx];
    assign h_exc     = x_a[head_idx];
    assign retire    = !empty && d_a[head_idx];
    assign flush_now = retire && (h_exc || (h_kind == K_BRANCH && m_a[head_idx]));

    // issue side: a slot is free, or one is leaving, and no flush is under way
    assign alloc_ready = (!full || retire) && !flush_now;
    assign alloc_fire  = alloc_valid && rs_free && alloc_ready;
    assign alloc_tag   = tail_idx;

    // retirement side effects
    assign retire_valid = retire;
    assign retire_tag   = head_idx;
    assign rf_we        = retire && !h_exc && (h_kind == K_REG);
    assign rf_addr      = r_a[head_idx];
    assign rf_data      = val_a[head_idx];
    assign st_we        = retire && !h_exc && (h_kind == K_STORE);
    assign st_addr      = adr_a[head_idx];
    assign st_data      = val_a[head_idx];
    assign exc_valid    = retire && h_exc;
    assign exc_pc       = p_a[head_idx];
    assign flush        = flush_now;
endmodule

// File: rtl/rob_core_chk.sv
// Assertion checker for rob_core. Keeps its own occupancy count and its
// own expected head and tail tags, derived only from port activity.
module rob_core_chk #(
    parameter int ENTRIES = 8,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             rs_free,
    input logic             alloc_ready,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             retire_valid,
    input logic [TAG_W-1:0] retire_tag,
    input logic             rf_we,
    input logic             st_we,
    input logic             exc_valid,
    input logic             flush
);
    logic [TAG_W+1:0] cnt;
    logic [TAG_W-1:0] exp_head, exp_tail;
    logic             fire;

    assign fire = alloc_valid && rs_free && alloc_ready;

    // shadow occupancy and tag sequence from port traffic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            exp_head <= '0;
            exp_tail <= '0;
        end else begin
            if (flush)
                cnt <= '0;
            else
                cnt <= cnt + (TAG_W+2)'(fire) - (TAG_W+2)'(retire_valid);
            if (retire_valid)
                exp_head <= exp_head + TAG_W'(1);
            if (flush)
                exp_tail <= exp_head + TAG_W'(1);
            else if (fire)
                exp_tail <= exp_tail + TAG_W'(1);
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (TAG_W+2)'(ENTRIES));
    // R2
    tag_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> alloc_tag == exp_tail);
    // R2
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == (TAG_W+2)'(ENTRIES) && !retire_valid) |-> !alloc_ready);
    // R4
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> retire_tag == exp_head);
    // R4
    retire_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !retire_valid);
    // R9
    exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (flush && !rf_we && !st_we));
    // R10
    flush_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_ready);
    // R8
    flush_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !retire_valid);
    // R5
    effect_needs_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || st_we || exc_valid || flush) |-> retire_valid);
    // R6
    single_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && st_we));
endmodule

bind rob_core rob_core_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .rs_free(rs_free),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .retire_valid(retire_valid), .retire_tag(retire_tag),
    .rf_we(rf_we), .st_we(st_we), .exc_valid(exc_valid), .flush(flush)
);

// File: tb/sim_rob_core.sv
// Bench for rob_core: a behavioural queue model checked against the ports on every cycle.
module sim_rob_core;
    localparam int N  = 4;
    localparam int XL = 32;
    localparam int PW = 32;
    localparam int AW = 3;
    localparam int TW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          alloc_valid, rs_free, wb_valid, wb_exc, wb_mispred;
    logic [1:0]    alloc_kind;
    logic [PW-1:0] alloc_pc;
    logic [AW-1:0] alloc_dest, lk_reg;
    logic [TW-1:0] wb_tag;
    logic [XL-1:0] wb_value, wb_addr;
    logic          alloc_ready, lk_hit, lk_ready, retire_valid, rf_we, st_we, exc_valid, flush;
    logic [TW-1:0] alloc_tag, lk_tag, retire_tag;
    logic [XL-1:0] lk_value, rf_data, st_addr, st_data;
    logic [AW-1:0] rf_addr;
    logic [PW-1:0] exc_pc;

    rob_core #(.ENTRIES(N), .XLEN(XL), .PC_W(PW), .AREG_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .rs_free(rs_free),
        .alloc_kind(alloc_kind), .alloc_pc(alloc_pc), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_addr(wb_addr),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred),
        .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_value(lk_value),
        .retire_valid(retire_valid), .retire_tag(retire_tag),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
        .exc_valid(exc_valid), .exc_pc(exc_pc), .flush(flush)
    );

    typedef struct {
        int          tag;
        int          kind;
        logic [31:0] pc;
        int          dest;
        bit          done, exc, mis;
        logic [31:0] val, addr;
    } ment_t;

    ment_t q[$];
    int mh, mt;
    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; rs_free = 1; alloc_kind = 0; alloc_pc = '0; alloc_dest = '0;
        wb_valid = 0; wb_tag = '0; wb_value = '0; wb_addr = '0; wb_exc = 0; wb_mispred = 0;
    endtask

    task automatic alloc(input int kind, input int pc, input int dest);
        alloc_valid = 1; rs_free = 1; alloc_kind = kind[1:0];
        alloc_pc = pc; alloc_dest = dest[AW-1:0];
    endtask

    task automatic wb(input int tag, input int val, input int addr, input bit ex, input bit mis);
        wb_valid = 1; wb_tag = tag[TW-1:0]; wb_value = val; wb_addr = addr;
        wb_exc = ex; wb_mispred = mis;
    endtask

    task automatic probe();
        #1;
    endtask

    // compare every output with the model, then advance the model on the clock edge
    task automatic tick();
        bit r, fl, rdy, hit, lr;
        int lt;
        logic [31:0] lv;
        ment_t h, n;
        #8;
        r  = (q.size() > 0) && q[0].done;
        if (r) h = q[0];
        fl  = r && (h.exc || (h.kind == 2 && h.mis));
        rdy = ((q.size() < N) || r) && !fl;
        chk("R2/R10/R11/R12", "alloc_ready", alloc_ready, rdy);
        chk("R2", "alloc_tag", alloc_tag, mt);
        chk("R4", "retire_valid", retire_valid, r);
        if (r) chk("R4", "retire_tag", retire_tag, h.tag);
        chk("R5", "rf_we", rf_we, r && !h.exc && h.kind == 0);
        if (r && !h.exc && h.kind == 0) begin
            chk("R5", "rf_addr", rf_addr, h.dest);
            chk("R5", "rf_data", rf_data, h.val);
        end
        chk("R6", "st_we", st_we, r && !h.exc && h.kind == 1);
        if (r && !h.exc && h.kind == 1) begin
            chk("R6", "st_addr", st_addr, h.addr);
            chk("R6", "st_data", st_data, h.val);
        end
        chk("R9", "exc_valid", exc_valid, r && h.exc);
        if (r && h.exc) chk("R9", "exc_pc", exc_pc, h.pc);
        chk("R8", "flush", flush, fl);
        hit = 0; lt = 0; lr = 0; lv = '0;
        foreach (q[i]) if (q[i].kind == 0 && q[i].dest == int'(lk_reg)) begin
            hit = 1; lt = q[i].tag; lr = q[i].done; lv = q[i].done ? q[i].val : '0;
        end
        chk("R7", "lk_hit", lk_hit, hit);
        chk("R7", "lk_tag", lk_tag, lt);
        chk("R7", "lk_ready", lk_ready, lr);
        chk("R7", "lk_value", lk_value, lv);
        @(posedge clk);
        if (wb_valid)
            foreach (q[i]) if (q[i].tag == int'(wb_tag)) begin
                q[i].done = 1; q[i].val = wb_value; q[i].addr = wb_addr;
                q[i].exc = wb_exc; q[i].mis = wb_mispred;
            end
        if (r) begin
            void'(q.pop_front());
            mh = (mh + 1) % N;
            if (fl) begin
                q.delete();
                mt = mh;
            end
        end
        if (alloc_valid && rs_free && rdy) begin
            n.tag = mt; n.kind = int'(alloc_kind); n.pc = alloc_pc; n.dest = int'(alloc_dest);
            n.done = 0; n.exc = 0; n.mis = 0; n.val = '0; n.addr = '0;
            q.push_back(n);
            mt = (mt + 1) % N;
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(); lk_reg = '0;
        mh = 0; mt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        probe();
        chk("R1", "alloc_ready", alloc_ready, 1);
        chk("R1", "alloc_tag", alloc_tag, 0);
        chk("R1", "retire_valid", retire_valid, 0);
        chk("R1", "lk_hit", lk_hit, 0);
        chk("R1", "flush", flush, 0);
        tick();

        // A: out-of-order completion, in-order retirement, youngest lookup
        alloc(0, 'h100, 1); tick();
        alloc(0, 'h104, 2); tick();
        alloc(0, 'h108, 1); tick();
        idle(); lk_reg = 1;
        probe();
        chk("R7", "youngest lk_hit", lk_hit, 1);
        chk("R7", "youngest lk_tag", lk_tag, 2);
        chk("R7", "youngest lk_ready", lk_ready, 0);
        wb(2, 'h22, 0, 0, 0); tick();
        idle(); probe();
        chk("R7", "forwarded lk_ready", lk_ready, 1);
        chk("R7", "forwarded lk_value", lk_value, 'h22);
        wb(1, 'h11, 0, 0, 0); tick();
        idle(); probe();
        chk("R4", "head not done retire_valid", retire_valid, 0);
        wb(0, 'h10, 0, 0, 0); tick();
        idle(); probe();
        chk("R5", "rf_we", rf_we, 1);
        chk("R5", "rf_addr", rf_addr, 1);
        chk("R5", "rf_data", rf_data, 'h10);
        tick(); tick(); tick();

        // B: fill, block, retire and allocate in the same full cycle
        lk_reg = 0;
        alloc(0, 'h110, 3); tick();
        alloc(0, 'h114, 4); tick();
        alloc(0, 'h118, 5); tick();
        alloc(0, 'h11c, 6); tick();
        alloc(0, 'h120, 7); probe();
        chk("R2", "full alloc_ready", alloc_ready, 0);
        wb(3, 'h33, 0, 0, 0); tick();
        wb_valid = 0; probe();
        chk("R11", "full with retire alloc_ready", alloc_ready, 1);
        chk("R11", "retire_tag", retire_tag, 3);
        tick();
        idle(); probe();
        chk("R11", "reused tag full again alloc_ready", alloc_ready, 0);
        chk("R11", "alloc_tag", alloc_tag, 0);
        for (int t = 0; t < 4; t++) begin
            wb(t, 'h40 + t, 0, 0, 0); tick();
        end
        idle();
        repeat (4) tick();

        // C: no reservation station
        alloc(0, 'h130, 2); rs_free = 0; tick();
        idle(); probe();
        chk("R12", "alloc_tag unchanged", alloc_tag, 0);
        chk("R12", "retire_valid", retire_valid, 0);
        tick();

        // D: store retirement
        alloc(1, 'h200, 0); tick();
        idle(); wb(0, 'hDEAD, 'h80, 0, 0); tick();
        idle(); probe();
        chk("R6", "st_we", st_we, 1);
        chk("R6", "st_addr", st_addr, 'h80);
        chk("R6", "st_data", st_data, 'hDEAD);
        chk("R6", "rf_we", rf_we, 0);
        tick();

        // E: mispredicted branch flush, then a correctly predicted branch
        alloc(2, 'h300, 0); tick();
        alloc(0, 'h304, 3); tick();
        alloc(0, 'h308, 4); tick();
        idle(); wb(3, 'h5, 0, 0, 0); tick();
        wb(2, 'h6, 0, 0, 0); tick();
        wb(1, 0, 0, 0, 1); tick();
        idle(); alloc(0, 'h30c, 5); probe();
        chk("R8", "flush", flush, 1);
        chk("R10", "alloc_ready in flush", alloc_ready, 0);
        chk("R8", "retire_tag", retire_tag, 1);
        chk("R8", "rf_we", rf_we, 0);
        tick();
        idle(); lk_reg = 3; probe();
        chk("R8", "retire after flush", retire_valid, 0);
        chk("R8", "alloc_tag after flush", alloc_tag, 2);
        chk("R8", "discarded lk_hit", lk_hit, 0);
        tick();
        alloc(2, 'h310, 0); tick();
        alloc(0, 'h314, 6); tick();
        idle(); wb(2, 0, 0, 0, 0); tick();
        idle(); probe();
        chk("R8", "good branch flush", flush, 0);
        chk("R8", "good branch retire", retire_valid, 1);
        tick();
        wb(3, 'h66, 0, 0, 0); tick();
        idle(); tick();

        // F: exception at retirement
        alloc(0, 'h3c0, 5); tick();
        alloc(0, 'h3c4, 6); tick();
        idle(); wb(0, 'h99, 0, 1, 0); tick();
        idle(); probe();
        chk("R9", "exc_valid", exc_valid, 1);
        chk("R9", "exc_pc", exc_pc, 'h3c0);
        chk("R9", "rf_we", rf_we, 0);
        chk("R9", "flush", flush, 1);
        tick();
        probe();
        chk("R9", "younger discarded", retire_valid, 0);
        tick();

        // G: broadcast to a free tag is ignored
        wb(1, 'h77, 0, 0, 0); tick();
        idle(); alloc(0, 'h400, 2); tick();
        idle(); lk_reg = 2; probe();
        chk("R3", "stale broadcast retire_valid", retire_valid, 0);
        chk("R3", "stale broadcast lk_ready", lk_ready, 0);
        wb(1, 'h78, 0, 0, 0); tick();
        idle(); probe();
        chk("R3", "retire_valid", retire_valid, 1);
        chk("R3", "rf_data", rf_data, 'h78);
        tick();

        // H: random traffic
        for (int c = 0; c < 4000; c++) begin
            alloc_valid = ($urandom % 3) != 0;
            rs_free     = ($urandom % 4) != 0;
            alloc_kind  = 2'($urandom);
            alloc_pc    = $urandom;
            alloc_dest  = AW'($urandom);
            wb_valid    = ($urandom % 2) == 0;
            wb_tag      = TW'($urandom);
            wb_value    = $urandom;
            wb_addr     = $urandom;
            wb_exc      = ($urandom % 16) == 0;
            wb_mispred  = ($urandom % 4) == 0;
            lk_reg      = AW'($urandom);
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule